// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds four status flags that let software work out, after the fact, which kind of reset or wake-up the chip last went through. The flags are a power-on flag, a brown-out flag, a watchdog time-out flag and a power-down flag. Hardware strobes tell the block which event happened: brown-out reset, watchdog reset, watchdog wake-up from sleep, external reset while running, external reset while asleep, sleep entry and watchdog clear. The block's own synchronous reset is the power-on event.

Each flag has its own rule for each event: some events set it, some clear it and some leave it alone. Because the rules differ, the combination of flags tells the causes apart. Software reads all four flags over a small register bus with two addresses. It may also write the power-on and brown-out flags, which it must set to 1 after each reset so that the next clearing event can be seen. When several strobes arrive in one cycle, a fixed priority picks the one that takes effect.

Top module: `rstcause_status`

## Requirements
- R1: While `rst` is high, the flags take power-on, brown-out, time-out and power-down values of 0, 1, 1 and 1, whatever else is asserted.
- R2: A brown-out strobe clears the brown-out flag, sets the time-out and power-down flags to 1 and keeps the power-on flag.
- R3: A watchdog reset strobe clears the time-out flag and keeps the other three flags.
- R4: A watchdog wake strobe clears both the time-out and power-down flags and keeps the power-on and brown-out flags.
- R5: An external reset strobe during run changes no flag, and it blocks the sleep, watchdog clear and bus write actions of the same cycle.
- R6: An external reset strobe during sleep sets the time-out flag to 1, clears the power-down flag and keeps the other two flags.
- R7: A sleep entry strobe sets time-out to 1 and power-down to 0. A watchdog clear strobe sets both to 1. Neither touches the power-on or brown-out flags.
- R8: A bus write to address 0 loads write-data bit 1 into the power-on flag and bit 0 into the brown-out flag. It takes effect only in a cycle with no event strobe. A write to address 1 has no effect.
- R9: The read data at address 0 is power-on in bit 1 and brown-out in bit 0. At address 1 it is time-out in bit 1 and power-down in bit 0. All other bits read 0.
- R10: When strobes coincide, only the highest one acts. The order, highest first, is: brown-out, watchdog reset, watchdog wake, external reset in sleep, external reset in run, sleep entry, watchdog clear.
- R11: With the parameter `BOR_EN` = 0, the brown-out flag always reads 1. Brown-out strobes and bus writes cannot change it, while the brown-out strobe still drives time-out and power-down as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ev_bor | input | 1 | Brown-out reset strobe |
| ev_wdt_rst | input | 1 | Watchdog reset strobe (normal run) |
| ev_wdt_wake | input | 1 | Watchdog wake-up strobe (from sleep) |
| ev_ext_sleep | input | 1 | External reset strobe while asleep |
| ev_ext_run | input | 1 | External reset strobe while running |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_wdt_clr | input | 1 | Watchdog clear strobe |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address (0 = reset flags, 1 = power state) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |

## Verification
The bench drives the strobes one at a time and in colliding pairs. A priority encoder ordered wrongly would let a watchdog reset override a brown-out, or a sleep strobe slip past an external run reset, and the time-out and power-down bits read back would then differ. Bus writes are placed on the same cycles as events, and also aimed at the read-only address. A design that lets software win over hardware would show a power-on or brown-out flag of 1 where 0 belongs. A second instance with brown-out detection absent checks that its brown-out bit stays 1 through brown-out strobes and zero writes. A long pseudo-random stretch compares every read-back bit, upper bits included, against a behavioural model.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    // Stored flags; bit order of this struct is only internal.
    typedef struct packed {
        logic por;   // power-on flag, 0 = power-on happened
        logic bor;   // brown-out flag, 0 = brown-out happened
        logic to;    // time-out flag, 0 = watchdog fired
        logic pd;    // power-down flag, 0 = sleep was entered
    } flags_t;

    // Event strobes gathered into one vector.
    typedef struct packed {
        logic bor;
        logic wdt_rst;
        logic wdt_wake;
        logic ext_sleep;
        logic ext_run;
        logic sleep;
        logic wdt_clr;
    } events_t;

    // Winning event of a cycle.
    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_BOR       = 3'd1,
        CAUSE_WDT_RST   = 3'd2,
        CAUSE_WDT_WAKE  = 3'd3,
        CAUSE_EXT_SLEEP = 3'd4,
        CAUSE_EXT_RUN   = 3'd5,
        CAUSE_SLEEP     = 3'd6,
        CAUSE_WDT_CLR   = 3'd7
    } cause_e;

    localparam flags_t FLAGS_POWER_ON = '{por: 1'b0, bor: 1'b1, to: 1'b1, pd: 1'b1};

    // Register addresses
    localparam int unsigned ADDR_RSTFLAGS = 0;
    localparam int unsigned ADDR_PWRSTATE = 1;

    // Bit positions inside each readable register
    localparam int unsigned BIT_LO = 0;
    localparam int unsigned BIT_HI = 1;

    // Per-event flag update; everything not named is held.
    function automatic flags_t apply_cause(input flags_t cur, input cause_e c);
        flags_t n;
        n = cur;
        unique case (c)
            CAUSE_BOR:       begin n.bor = 1'b0; n.to = 1'b1; n.pd = 1'b1; end
            CAUSE_WDT_RST:   begin n.to = 1'b0; end
            CAUSE_WDT_WAKE:  begin n.to = 1'b0; n.pd = 1'b0; end
            CAUSE_EXT_SLEEP: begin n.to = 1'b1; n.pd = 1'b0; end
            CAUSE_EXT_RUN:   begin end
            CAUSE_SLEEP:     begin n.to = 1'b1; n.pd = 1'b0; end
            CAUSE_WDT_CLR:   begin n.to = 1'b1; n.pd = 1'b1; end
            default:         begin end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rstcause_prio.sv
module rstcause_prio
    import rstcause_pkg::*;
(
    input  events_t ev,
    output cause_e  cause
);
    // Fixed priority, highest first.
    always_comb begin
        if (ev.bor)            cause = CAUSE_BOR;
        else if (ev.wdt_rst)   cause = CAUSE_WDT_RST;
        else if (ev.wdt_wake)  cause = CAUSE_WDT_WAKE;
        else if (ev.ext_sleep) cause = CAUSE_EXT_SLEEP;
        else if (ev.ext_run)   cause = CAUSE_EXT_RUN;
        else if (ev.sleep)     cause = CAUSE_SLEEP;
        else if (ev.wdt_clr)   cause = CAUSE_WDT_CLR;
        else                   cause = CAUSE_NONE;
    end
endmodule

// File: rtl/rstcause_core.sv
module rstcause_core
    import rstcause_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 1,
    parameter bit          BOR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  cause_e            cause,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output flags_t            flags
);
    flags_t flags_q;
    flags_t nxt_raw;
    flags_t nxt;
    logic   sw_write;

    // Software only wins in a cycle with no hardware event at all.
    assign sw_write = wr && (addr == ADDR_W'(ADDR_RSTFLAGS)) && (cause == CAUSE_NONE);

    always_comb begin
        nxt_raw = apply_cause(flags_q, cause);
        if (sw_write) begin
            nxt_raw.por = wdata[BIT_HI];
            nxt_raw.bor = wdata[BIT_LO];
        end
    end

    generate
        if (BOR_EN) begin : g_bor_live
            assign nxt = nxt_raw;
        end else begin : g_bor_absent
            always_comb begin
                nxt     = nxt_raw;
                nxt.bor = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAGS_POWER_ON;
        else     flags_q <= nxt;
    end

    assign flags = flags_q;
endmodule

// File: rtl/rstcause_rdmux.sv
module rstcause_rdmux
    import rstcause_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 1
) (
    input  flags_t            flags,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_RSTFLAGS)) begin
            rdata[BIT_HI] = flags.por;
            rdata[BIT_LO] = flags.bor;
        end else if (addr == ADDR_W'(ADDR_PWRSTATE)) begin
            rdata[BIT_HI] = flags.to;
            rdata[BIT_LO] = flags.pd;
        end
    end
endmodule

// File: rtl/rstcause_status.sv
module rstcause_status
    import rstcause_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 1,
    parameter bit          BOR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_bor,
    input  logic              ev_wdt_rst,
    input  logic              ev_wdt_wake,
    input  logic              ev_ext_sleep,
    input  logic              ev_ext_run,
    input  logic              ev_sleep,
    input  logic              ev_wdt_clr,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    events_t ev;
    cause_e  cause;
    flags_t  flags_q;

    assign ev = '{bor: ev_bor, wdt_rst: ev_wdt_rst, wdt_wake: ev_wdt_wake,
                  ext_sleep: ev_ext_sleep, ext_run: ev_ext_run,
                  sleep: ev_sleep, wdt_clr: ev_wdt_clr};

    rstcause_prio u_prio (
        .ev    (ev),
        .cause (cause)
    );

    rstcause_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOR_EN(BOR_EN)) u_core (
        .clk   (clk),
        .rst   (rst),
        .cause (cause),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .flags (flags_q)
    );

    rstcause_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .flags (flags_q),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/rstcause_checker.sv
module rstcause_checker #(
    parameter int unsigned ADDR_W = 1,
    parameter bit          BOR_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_bor,
    input logic              ev_wdt_rst,
    input logic              ev_wdt_wake,
    input logic              ev_ext_sleep,
    input logic              ev_ext_run,
    input logic              ev_sleep,
    input logic              ev_wdt_clr,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        flags    // {por, bor, to, pd}
);
    AST_POWER_ON_VALUES: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> flags == 4'b0111); // R1

    AST_WDT_RST_TO: assert property (@(posedge clk) disable iff (rst)
        (ev_wdt_rst && !ev_bor) |=> (!flags[1] && flags[3] == $past(flags[3])
                                     && flags[0] == $past(flags[0]))); // R3

    AST_WDT_WAKE_BOTH: assert property (@(posedge clk) disable iff (rst)
        (ev_wdt_wake && !ev_wdt_rst && !ev_bor) |=> flags[1:0] == 2'b00); // R4

    AST_EXT_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev_ext_run && !ev_bor && !ev_wdt_rst && !ev_wdt_wake && !ev_ext_sleep)
        |=> $stable(flags)); // R5

    AST_EXT_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (ev_ext_sleep && !ev_bor && !ev_wdt_rst && !ev_wdt_wake)
        |=> flags[1:0] == 2'b10); // R6

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (ev_sleep && !ev_bor && !ev_wdt_rst && !ev_wdt_wake && !ev_ext_sleep && !ev_ext_run)
        |=> flags[1:0] == 2'b10); // R7

    AST_POR_SET_BY_SW: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[3]) |-> $past(bus_wr && bus_addr == '0)); // R8

    generate
        if (BOR_EN) begin : g_bor_chk
            AST_BOR_CLEARS: assert property (@(posedge clk) disable iff (rst)
                ev_bor |=> (flags[2:0] == 3'b011 && flags[3] == $past(flags[3]))); // R2
        end else begin : g_nobor_chk
            AST_BOR_STUCK: assert property (@(posedge clk) disable iff (rst)
                flags[2]); // R11
        end
    endgenerate
endmodule

bind rstcause_status rstcause_checker #(.ADDR_W(ADDR_W), .BOR_EN(BOR_EN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_bor       (ev_bor),
    .ev_wdt_rst   (ev_wdt_rst),
    .ev_wdt_wake  (ev_wdt_wake),
    .ev_ext_sleep (ev_ext_sleep),
    .ev_ext_run   (ev_ext_run),
    .ev_sleep     (ev_sleep),
    .ev_wdt_clr   (ev_wdt_clr),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .flags        (flags_q)
);

// File: tb/rstcause_status_bench.sv
`timescale 1ns/100ps
module rstcause_status_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 1;
    // Event vector bit order used by the bench
    localparam logic [6:0] E_BOR   = 7'h40;
    localparam logic [6:0] E_WRST  = 7'h20;
    localparam logic [6:0] E_WAKE  = 7'h10;
    localparam logic [6:0] E_XSLP  = 7'h08;
    localparam logic [6:0] E_XRUN  = 7'h04;
    localparam logic [6:0] E_SLEEP = 7'h02;
    localparam logic [6:0] E_CLR   = 7'h01;
    localparam logic [6:0] E_NONE  = 7'h00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [6:0] ev = '0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] rdata_a, rdata_b;

    int tests = 0;
    int fails = 0;
    bit reported = 0;

    // Reference model state: instance a (brown-out live), b (absent)
    int m_por, m_bor, m_to, m_pd, m_bor_b, m_to_b, m_pd_b;

    always #2.5 clk = ~clk;

    rstcause_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOR_EN(1'b1)) u_rstcause_status (
        .clk(clk), .rst(rst), .ev_bor(ev[6]), .ev_wdt_rst(ev[5]), .ev_wdt_wake(ev[4]),
        .ev_ext_sleep(ev[3]), .ev_ext_run(ev[2]), .ev_sleep(ev[1]), .ev_wdt_clr(ev[0]),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a));

    rstcause_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOR_EN(1'b0)) u_rstcause_status_nb (
        .clk(clk), .rst(rst), .ev_bor(ev[6]), .ev_wdt_rst(ev[5]), .ev_wdt_wake(ev[4]),
        .ev_ext_sleep(ev[3]), .ev_ext_run(ev[2]), .ev_sleep(ev[1]), .ev_wdt_clr(ev[0]),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b));

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%02h expected=%02h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: winner of the cycle, then the effect on each flag.
    task automatic model(input logic r, input logic [6:0] e, input logic w,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int to_n, pd_n;
        to_n = m_to; pd_n = m_pd;
        if (r) begin
            m_por = 0; m_bor = 1; to_n = 1; pd_n = 1;
        end else if (e[6]) begin
            m_bor = 0; to_n = 1; pd_n = 1;
        end else if (e[5]) begin
            to_n = 0;
        end else if (e[4]) begin
            to_n = 0; pd_n = 0;
        end else if (e[3]) begin
            to_n = 1; pd_n = 0;
        end else if (e[2]) begin
            // nothing changes
        end else if (e[1]) begin
            to_n = 1; pd_n = 0;
        end else if (e[0]) begin
            to_n = 1; pd_n = 1;
        end else if (w && a == 0) begin
            m_por = d[1]; m_bor = d[0];
        end
        m_to = to_n; m_pd = pd_n;
        m_to_b = to_n; m_pd_b = pd_n; m_bor_b = 1;
    endtask

    // One clock: drive at negedge, model at posedge, read both registers after.
    task automatic cyc(input string tag, input logic r, input logic [6:0] e,
                       input logic w = 1'b0, input logic [ADDR_W-1:0] a = '0,
                       input logic [DATA_W-1:0] d = '0);
        rst = r; ev = e; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #0.5;
        model(r, e, w, a, d);
        bus_wr = 1'b0;
        bus_addr = ADDR_W'(0);
        #0.2;
        check({tag, " rstflags"}, rdata_a, {6'b0, m_por[0], m_bor[0]});
        check("R11 rstflags no-bor", rdata_b, {6'b0, m_por[0], m_bor_b[0]});
        bus_addr = ADDR_W'(1);
        #0.2;
        check({tag, " pwrstate"}, rdata_a, {6'b0, m_to[0], m_pd[0]});
        check("R11 pwrstate no-bor", rdata_b, {6'b0, m_to_b[0], m_pd_b[0]});
        @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        logic [15:0] lfsr;
        m_por = 0; m_bor = 1; m_to = 1; m_pd = 1; m_bor_b = 1; m_to_b = 1; m_pd_b = 1;
        @(negedge clk);
        cyc("R1 reset", 1, E_NONE);
        cyc("R1 reset with events", 1, E_BOR | E_WRST | E_SLEEP, 1, '0, 8'h03);
        cyc("R1 released", 0, E_NONE);
        cyc("R8 sw set flags", 0, E_NONE, 1, '0, 8'h03);
        cyc("R3 watchdog reset", 0, E_WRST);
        cyc("R7 watchdog clear", 0, E_CLR);
        cyc("R7 sleep entry", 0, E_SLEEP);
        cyc("R4 watchdog wake", 0, E_WAKE);
        cyc("R6 ext reset in sleep", 0, E_XSLP);
        cyc("R5 ext reset in run", 0, E_XRUN);
        cyc("R5 ext run blocks write", 0, E_XRUN, 1, '0, 8'h00);
        cyc("R8 write to addr1 ignored", 0, E_NONE, 1, ADDR_W'(1), 8'h00);
        cyc("R2 brown-out", 0, E_BOR);
        cyc("R9 upper bits read zero", 0, E_NONE, 1, '0, 8'hFF);
        cyc("R8 write zero por", 0, E_NONE, 1, '0, 8'h01);
        cyc("R8 write por back", 0, E_NONE, 1, '0, 8'h03);
        cyc("R10 bor over wdt", 0, E_BOR | E_WRST);
        cyc("R8 restore", 0, E_NONE, 1, '0, 8'h03);
        cyc("R10 wdt reset over wake", 0, E_WRST | E_WAKE);
        cyc("R7 clear", 0, E_CLR);
        cyc("R10 ext sleep over clear", 0, E_XSLP | E_CLR);
        cyc("R7 clear again", 0, E_CLR);
        cyc("R10 ext run over sleep", 0, E_XRUN | E_SLEEP);
        cyc("R10 sleep over clear", 0, E_SLEEP | E_CLR);
        cyc("R10 wake over ext sleep", 0, E_WAKE | E_XSLP);
        cyc("R8 event blocks write", 0, E_CLR, 1, '0, 8'h00);
        cyc("R2 brown-out blocks write", 0, E_BOR, 1, '0, 8'h03);
        cyc("R1 reset again", 1, E_NONE);
        cyc("R1 release", 0, E_NONE);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [6:0] e;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e = (lfsr[3:0] < 4'd9) ? (7'h01 << lfsr[6:4]) & 7'h7F : 7'h00;
            if (lfsr[15:12] == 4'hF) e = e | (7'h01 << lfsr[11:9]);
            cyc("R10 mixed", (lfsr[15:8] == 8'h5A), e, lfsr[7], ADDR_W'(lfsr[8]),
                {lfsr[11:4]});
        end
        report();
    end
endmodule